// File: doc/BRIEF.md
# SD Card Clock Divider

This block derives the SD card clock from a base clock. A host writes a control word through a single write strobe. The word carries an internal clock enable, an SD clock enable, a divisor encoding select and a ten-bit divider value, which is split into an eight-bit low field and a two-bit high field. The block reports when its internal clock has settled. It drives the card clock only when the clock is stable and the host has opened the SD clock gate.

Two divisor encodings are available. The power-of-two encoding reads only the low field. The highest set bit k of that field selects a divide ratio of 2^(k+1). The linear encoding reads all ten bits as N and divides by 2N. In both encodings a value of zero passes the base clock straight through. A preset-select input can replace the host-written divider value with an externally supplied value.

The divider value and encoding are sampled into the active settings only while the card clock is stopped and idle. A card clock that is running therefore never changes rate and never produces a short pulse.

Top module: `sdclk_gen`

## Requirements
- R1: After reset, every register field is zero, `clk_stable` is 0 and `sd_clk` is low.
- R2: After a write sets the internal clock enable, `clk_stable` is 0 for the first STABLE_CYCLES-1 base-clock edges and rises at edge STABLE_CYCLES. After a write clears that enable, `clk_stable` is 0 right after the same edge.
- R3: `sd_clk` stays low while the SD clock enable is 0 or `clk_stable` is 0. An ongoing high phase is allowed to complete first.
- R4: With `reg_mode`=0 (power-of-two) and exactly one bit k set in the low field, `sd_clk` has a period of 2^(k+1) base cycles with a 50% duty cycle. Examples: 01h gives /2 and 80h gives /256.
- R5: With `reg_mode`=0, only the most significant set bit of the low field selects the ratio, and the high field is ignored. Examples: 03h gives /4, A4h gives /256, and high=3 with low=04h gives /8.
- R6: With `reg_mode`=1 (linear), a value N={high,low} from 1 to 3FFh gives a period of 2N base cycles with a 50% duty cycle. Examples: 001h gives /2, 100h gives /512 and 3FFh gives /2046.
- R7: A divider value of zero in either mode makes `sd_clk` follow the base clock: high while the base clock is high and low while it is low.
- R8: While `preset_en`=1, `preset_val` is used as the divider value in place of the written fields.
- R9: A new divider value written while the SD clock runs has no effect until the SD clock enable has been 0 and set again.
- R10: For a 33 MHz base clock, power-of-two value 01h yields a period of 2 cycles (16.5 MHz) and 40h yields a period of 128 cycles (about 258 kHz).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Control word write strobe |
| reg_icken | input | 1 | Internal clock enable to write |
| reg_sdcken | input | 1 | SD clock enable to write |
| reg_mode | input | 1 | Divisor encoding: 0 power-of-two, 1 linear |
| reg_div_lo | input | 8 | Low divider field to write |
| reg_div_hi | input | 2 | High divider field to write (linear mode only) |
| preset_en | input | 1 | Use `preset_val` as the divider value |
| preset_val | input | 10 | Preset divider value |
| sd_clk | output | 1 | Divided, gated SD card clock |
| clk_stable | output | 1 | Internal clock stable status |

## Verification
The bench builds the block with STABLE_CYCLES=5. At that value the settling window is short enough to check the stable status edge by edge, both just before and exactly at its rising edge. The divider widths stay at their defaults, so the bench can measure the extreme ratios /256 and /2046 in full within the cycle budget. A table of divider settings is then walked, with period and duty checked for each entry.

// File: rtl/sdclk_pkg.sv
package sdclk_pkg;
    localparam int DIV_LO_W = 8;
    localparam int DIV_HI_W = 2;
    localparam int DIV_W    = DIV_LO_W + DIV_HI_W;

    typedef logic [DIV_W-1:0] divval_t;

    typedef enum logic {
        MODE_POW2 = 1'b0,
        MODE_LIN  = 1'b1
    } div_mode_e;

    typedef struct packed {
        logic      icken;
        logic      sdcken;
        div_mode_e mode;
        divval_t   div;
    } clkctl_t;

    // Half period in base cycles; zero means pass-through.
    function automatic divval_t half_period(div_mode_e m, divval_t v);
        divval_t h;
        h = '0;
        if (m == MODE_LIN) begin
            h = v;
        end else begin
            for (int k = 0; k < DIV_LO_W; k++) begin
                if (v[k]) h = divval_t'(1) << k;
            end
        end
        return h;
    endfunction
endpackage

// File: rtl/sdclk_ctrl.sv
module sdclk_ctrl
    import sdclk_pkg::*;
#(
    parameter int STABLE_CYCLES = 16
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    we,
    input  clkctl_t wr,
    output clkctl_t ctl_q,
    output logic    stable
);
    localparam int SW = $clog2(STABLE_CYCLES + 1);

    logic [SW-1:0] st_cnt;
    logic          st_done;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q   <= '0;
            st_cnt  <= '0;
            st_done <= 1'b0;
        end else begin
            if (we) ctl_q <= wr;
            if (!ctl_q.icken) begin
                st_cnt  <= '0;
                st_done <= 1'b0;
            end else if (!st_done) begin
                if (st_cnt == SW'(STABLE_CYCLES - 1)) st_done <= 1'b1;
                else                                  st_cnt  <= st_cnt + 1'b1;
            end
        end
    end

    assign stable = ctl_q.icken & st_done;

    // R2: stability only follows an enable that was already registered
    assert_stable_after_enable_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(stable) |-> $past(ctl_q.icken));

    // R2: clearing the enable drops the status at once
    assert_stable_clears_R2: assert property (@(posedge clk) disable iff (rst)
        (we && !wr.icken) |=> !stable);
endmodule

// File: rtl/sdclk_div.sv
module sdclk_div
    import sdclk_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    run,
    input  divval_t sel_hp,
    output logic    sd_clk
);
    divval_t act_hp;
    divval_t cnt;
    logic    div_q;
    logic    gate_q;
    logic    idle;
    logic    bypass;

    assign idle   = !run && !div_q && !gate_q;
    assign bypass = (act_hp == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            act_hp <= '0;
            cnt    <= '0;
            div_q  <= 1'b0;
        end else if (idle) begin
            act_hp <= sel_hp;
            cnt    <= '0;
        end else if (!bypass) begin
            if (cnt == act_hp - 1'b1) begin
                cnt   <= '0;
                div_q <= run ? ~div_q : 1'b0;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    // Gate for pass-through changes only while the base clock is low.
    always_ff @(negedge clk) begin
        if (rst) gate_q <= 1'b0;
        else     gate_q <= run && bypass;
    end

    assign sd_clk = bypass ? (clk & gate_q) : div_q;

    // R3: once stopped and low, the divided clock stays low
    assert_hold_low_R3: assert property (@(posedge clk) disable iff (rst)
        (!run && !div_q) |=> !div_q);

    // R6: half-period counter never passes its terminal value
    assert_cnt_range_R6: assert property (@(posedge clk) disable iff (rst)
        (act_hp != '0) |-> (cnt < act_hp));

    // R9: active ratio is frozen while the clock runs
    assert_ratio_frozen_R9: assert property (@(posedge clk) disable iff (rst)
        (run && $past(run)) |-> $stable(act_hp));

    // R7: pass-through gate is only open with a zero divider
    assert_gate_bypass_R7: assert property (@(posedge clk) disable iff (rst)
        gate_q |-> (act_hp == '0));
endmodule

// File: rtl/sdclk_gen.sv
module sdclk_gen
    import sdclk_pkg::*;
#(
    parameter int STABLE_CYCLES = 16
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                reg_we,
    input  logic                reg_icken,
    input  logic                reg_sdcken,
    input  logic                reg_mode,
    input  logic [DIV_LO_W-1:0] reg_div_lo,
    input  logic [DIV_HI_W-1:0] reg_div_hi,
    input  logic                preset_en,
    input  logic [DIV_W-1:0]    preset_val,
    output logic                sd_clk,
    output logic                clk_stable
);
    clkctl_t wr_word;
    clkctl_t ctl_q;
    divval_t src_div;
    divval_t sel_hp;
    logic    run;

    always_comb begin
        wr_word.icken  = reg_icken;
        wr_word.sdcken = reg_sdcken;
        wr_word.mode   = div_mode_e'(reg_mode);
        wr_word.div    = {reg_div_hi, reg_div_lo};
    end

    sdclk_ctrl #(.STABLE_CYCLES(STABLE_CYCLES)) u_ctrl (
        .clk    (clk),
        .rst    (rst),
        .we     (reg_we),
        .wr     (wr_word),
        .ctl_q  (ctl_q),
        .stable (clk_stable)
    );

    assign src_div = preset_en ? preset_val : ctl_q.div;
    assign sel_hp  = half_period(ctl_q.mode, src_div);
    assign run     = ctl_q.sdcken & clk_stable;

    sdclk_div u_div (
        .clk    (clk),
        .rst    (rst),
        .run    (run),
        .sel_hp (sel_hp),
        .sd_clk (sd_clk)
    );

    // R1: no clock output without a stable internal clock at the first edge
    assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!clk_stable && !sd_clk));
endmodule

// File: tb/sdclk_gen_test.sv
module sdclk_gen_test;
    localparam int ST = 5;
    localparam int NV = 12;
    // {mode, hi[1:0], lo[7:0], period[11:0]}
    localparam logic [22:0] VEC [NV] = '{
        {1'b0, 2'd0, 8'h01, 12'd2},
        {1'b0, 2'd0, 8'h02, 12'd4},
        {1'b0, 2'd0, 8'h40, 12'd128},
        {1'b0, 2'd0, 8'h80, 12'd256},
        {1'b0, 2'd0, 8'h03, 12'd4},
        {1'b0, 2'd0, 8'hA4, 12'd256},
        {1'b0, 2'd3, 8'h04, 12'd8},
        {1'b1, 2'd0, 8'h01, 12'd2},
        {1'b1, 2'd0, 8'h02, 12'd4},
        {1'b1, 2'd3, 8'hFF, 12'd2046},
        {1'b1, 2'd1, 8'h00, 12'd512},
        {1'b1, 2'd0, 8'h05, 12'd10}
    };
    localparam string TAG [NV] = '{"R4 R10", "R4", "R4 R10", "R4", "R5", "R5", "R5",
                                   "R6", "R6", "R6", "R6", "R6"};

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       reg_we = 1'b0, reg_icken = 1'b0, reg_sdcken = 1'b0, reg_mode = 1'b0;
    logic [7:0] reg_div_lo = '0;
    logic [1:0] reg_div_hi = '0;
    logic       preset_en = 1'b0;
    logic [9:0] preset_val = '0;
    logic       sd_clk, clk_stable;
    int         checks = 0, errors = 0;
    bit         done = 1'b0;

    always #2 clk = ~clk;

    sdclk_gen #(.STABLE_CYCLES(ST)) uut (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_icken(reg_icken),
        .reg_sdcken(reg_sdcken), .reg_mode(reg_mode), .reg_div_lo(reg_div_lo),
        .reg_div_hi(reg_div_hi), .preset_en(preset_en), .preset_val(preset_val),
        .sd_clk(sd_clk), .clk_stable(clk_stable)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(input bit ick, input bit sdck, input bit m,
                      input logic [1:0] hi, input logic [7:0] lo);
        @(negedge clk);
        reg_we = 1'b1; reg_icken = ick; reg_sdcken = sdck; reg_mode = m;
        reg_div_hi = hi; reg_div_lo = lo;
        @(posedge clk); #1;
        reg_we = 1'b0;
    endtask

    task automatic measure(output int per, output int hi);
        logic prev, cur;
        int   n;
        per = 0; hi = 0; n = 0;
        @(negedge clk); #1; prev = sd_clk;
        cur = prev;
        while (n < 5000) begin
            @(negedge clk); #1; cur = sd_clk;
            if (!prev && cur) break;
            prev = cur; n++;
        end
        do begin
            per++;
            if (cur) hi++;
            prev = cur;
            @(negedge clk); #1; cur = sd_clk;
        end while (!(!prev && cur) && per < 5000);
    endtask

    task automatic check_low(input string req);
        int highs;
        highs = 0;
        repeat (20) begin
            @(posedge clk); #1; if (sd_clk) highs++;
            @(negedge clk); #1; if (sd_clk) highs++;
        end
        chk(highs == 0, req, highs, 0);
    endtask

    task automatic check_follow(input string req);
        int bad;
        bad = 0;
        repeat (6) begin
            @(posedge clk); #1; if (sd_clk !== 1'b1) bad++;
            @(negedge clk); #1; if (sd_clk !== 1'b0) bad++;
        end
        chk(bad == 0, req, bad, 0);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int per, hi;
        repeat (3) @(posedge clk);
        #1;
        chk(sd_clk == 1'b0 && clk_stable == 1'b0, "R1 in reset", {sd_clk, clk_stable}, 0);
        @(negedge clk); rst = 1'b0;
        repeat (4) @(posedge clk);
        #1;
        chk(sd_clk == 1'b0 && clk_stable == 1'b0, "R1 after reset", {sd_clk, clk_stable}, 0);

        // R2: stability window, edge by edge
        wr(1'b1, 1'b0, 1'b0, 2'd0, 8'h01);
        for (int k = 1; k < ST; k++) begin
            @(posedge clk); #1;
            chk(clk_stable == 1'b0, "R2 early", clk_stable, 0);
        end
        @(posedge clk); #1;
        chk(clk_stable == 1'b1, "R2 rise", clk_stable, 1);

        // Table walk: R4 R5 R6 R10
        for (int i = 0; i < NV; i++) begin
            wr(1'b1, 1'b0, VEC[i][22], VEC[i][21:20], VEC[i][19:12]);
            repeat (1100) @(posedge clk);
            wr(1'b1, 1'b1, VEC[i][22], VEC[i][21:20], VEC[i][19:12]);
            measure(per, hi);
            chk(per == int'(VEC[i][11:0]), {TAG[i], " period"}, per, int'(VEC[i][11:0]));
            chk(hi == int'(VEC[i][11:0]) / 2, {TAG[i], " duty"}, hi, int'(VEC[i][11:0]) / 2);
        end

        // R9: change while running is deferred
        wr(1'b1, 1'b0, 1'b0, 2'd0, 8'h01);
        repeat (1100) @(posedge clk);
        wr(1'b1, 1'b1, 1'b0, 2'd0, 8'h01);
        repeat (4) @(posedge clk);
        wr(1'b1, 1'b1, 1'b0, 2'd0, 8'h10);
        measure(per, hi);
        chk(per == 2, "R9 deferred", per, 2);
        wr(1'b1, 1'b0, 1'b0, 2'd0, 8'h10);
        repeat (20) @(posedge clk);
        wr(1'b1, 1'b1, 1'b0, 2'd0, 8'h10);
        measure(per, hi);
        chk(per == 32, "R9 applied", per, 32);

        // R3: SD enable off
        wr(1'b1, 1'b0, 1'b0, 2'd0, 8'h01);
        repeat (40) @(posedge clk);
        check_low("R3 sd enable off");

        // R3 / R2: internal enable off with SD enable on
        wr(1'b1, 1'b1, 1'b0, 2'd0, 8'h01);
        repeat (4) @(posedge clk);
        wr(1'b0, 1'b1, 1'b0, 2'd0, 8'h01);
        chk(clk_stable == 1'b0, "R2 clear", clk_stable, 0);
        repeat (4) @(posedge clk);
        check_low("R3 not stable");
        wr(1'b1, 1'b0, 1'b0, 2'd0, 8'h01);
        repeat (ST + 4) @(posedge clk);

        // R7: pass-through in both modes
        wr(1'b1, 1'b0, 1'b0, 2'd0, 8'h00);
        repeat (10) @(posedge clk);
        wr(1'b1, 1'b1, 1'b0, 2'd0, 8'h00);
        repeat (3) @(posedge clk);
        check_follow("R7 pow2 zero");
        wr(1'b1, 1'b0, 1'b1, 2'd0, 8'h00);
        repeat (10) @(posedge clk);
        check_low("R3 bypass off");
        wr(1'b1, 1'b1, 1'b1, 2'd0, 8'h00);
        repeat (3) @(posedge clk);
        check_follow("R7 linear zero");

        // R8: preset overrides host field
        wr(1'b1, 1'b0, 1'b1, 2'd0, 8'h01);
        preset_en = 1'b1; preset_val = 10'h003;
        repeat (20) @(posedge clk);
        wr(1'b1, 1'b1, 1'b1, 2'd0, 8'h01);
        measure(per, hi);
        chk(per == 6, "R8 preset", per, 6);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule